// File: doc/BRIEF.md
# Page-Bounded Sequential Block Prefetcher

This block sits between a cache's miss detection and its refill path to memory. It takes one demand miss address at a time and issues memory fetch requests for it. The first request is the demand block. Up to four more requests follow for the next consecutive blocks, which is the prefetch run. Each request carries a flag that marks it as a demand fetch or a prefetch. Addresses are physical. Block size is 64 bytes and page size is 8 KB, both set in the package.

The block never lets a prefetch run reach into the next 8 KB page. A run shortens to the blocks left in the current page. A miss on the final block of a page therefore produces only its demand fetch. A new miss that arrives while a run is still being issued cancels the rest of that run, and the new miss's demand fetch goes out next.

Requests leave through a registered valid/ready port. Misses enter through a valid/ready port whose ready signal tracks whether the output register can take a new request.

Top module: `pfs_seq_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_valid` is 0 and `miss_ready` is 1.
- R2: A miss accepted at a clock edge makes a request visible after that edge. Its `fetch_addr` is the miss address with its low six bits (block offset) cleared, and `fetch_is_pf` is 0.
- R3: Prefetch requests follow the demand request, one per accepted handshake. Each prefetch has `fetch_is_pf` = 1 and an address one block (64) above the request before it.
- R4: A run holds min(4, 127 − b) prefetches, where b is address bits [12:7]… more exactly bits [12:6], the block index within the 8 KB page. No prefetch address differs from its demand address in bits [39:13].
- R5: A miss whose block index (bits [12:6]) is 127 produces the demand request and no prefetch.
- R6: A miss accepted while a run still has requests left cancels them. The next request is the new miss's demand request.
- R7: While `fetch_valid` is 1 and `fetch_ready` is 0, the request (valid, address, flag) is held unchanged into the next cycle.
- R8: `miss_ready` equals NOT `fetch_valid` OR `fetch_ready` in every cycle.
- R9: After the last request of a run is accepted, with no new miss, `fetch_valid` drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Demand miss address is offered |
| miss_ready | output | 1 | Block accepts the offered miss this cycle |
| miss_addr | input | 40 | Physical miss address (byte granular) |
| fetch_valid | output | 1 | Fetch request is presented |
| fetch_ready | input | 1 | Memory side accepts the request |
| fetch_addr | output | 40 | Block-aligned physical fetch address |
| fetch_is_pf | output | 1 | 1 = prefetch, 0 = demand |

## Verification
Misses are placed in the middle of a page, on the page's last block, and two blocks short of the page end. Together these show the full four-block run apart from a clipped run and a demand-only result. An address with nonzero offset bits checks the alignment. The same scenarios then run with `fetch_ready` toggling, which separates a held request from one that advances or is lost. Last, a second miss lands in the middle of a run, which shows cancellation apart from a run that simply continues.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    parameter int unsigned ADDR_W     = 40;
    parameter int unsigned BLK_BYTES  = 64;
    parameter int unsigned PAGE_BYTES = 8192;
    parameter int unsigned RUN_LEN    = 4;

    localparam int unsigned OFF_W     = $clog2(BLK_BYTES);
    localparam int unsigned PG_W      = $clog2(PAGE_BYTES);
    localparam int unsigned IDX_W     = PG_W - OFF_W;
    localparam int unsigned PAGE_BLKS = PAGE_BYTES / BLK_BYTES;
    localparam int unsigned CNT_W     = $clog2(RUN_LEN + 1);

    typedef logic [ADDR_W-1:0] paddr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [IDX_W-1:0]  bidx_t;

    typedef enum logic {
        KIND_DEMAND   = 1'b0,
        KIND_PREFETCH = 1'b1
    } fetch_kind_e;

    typedef struct packed {
        paddr_t      addr;
        fetch_kind_e kind;
    } fetch_req_t;

    function automatic paddr_t blk_align(input paddr_t a);
        paddr_t r;
        r = a;
        r[OFF_W-1:0] = '0;
        return r;
    endfunction

    function automatic bidx_t blk_index(input paddr_t a);
        return a[PG_W-1:OFF_W];
    endfunction

    function automatic cnt_t run_budget(input paddr_t a);
        int unsigned left;
        left = (PAGE_BLKS - 1) - int'(blk_index(a));
        if (left > RUN_LEN) return cnt_t'(RUN_LEN);
        return cnt_t'(left);
    endfunction

endpackage

// File: rtl/pfs_budget.sv
module pfs_budget
    import pfs_pkg::*;
(
    input  paddr_t miss_addr,
    output paddr_t demand_addr,
    output cnt_t   budget
);
    always_comb begin
        demand_addr = blk_align(miss_addr);
        budget      = run_budget(miss_addr);
    end
endmodule

// File: rtl/pfs_next_blk.sv
module pfs_next_blk
    import pfs_pkg::*;
(
    input  paddr_t cur_addr,
    output paddr_t nxt_addr,
    output logic   same_page
);
    always_comb begin
        nxt_addr  = cur_addr + paddr_t'(BLK_BYTES);
        same_page = (nxt_addr[ADDR_W-1:PG_W] == cur_addr[ADDR_W-1:PG_W]);
    end
endmodule

// File: rtl/pfs_run_ctrl.sv
module pfs_run_ctrl
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  paddr_t     in_addr,
    input  paddr_t     in_demand_addr,
    input  cnt_t       in_budget,
    input  paddr_t     step_addr,
    input  logic       step_same_page,
    output fetch_req_t out_q,
    output logic       out_valid,
    input  logic       out_ready
);
    cnt_t   remain_q;
    logic   advance;
    logic   take_miss;
    logic [ADDR_W-PG_W-1:0] dem_page_q;

    assign advance   = !out_valid || out_ready;
    assign in_ready  = advance;
    assign take_miss = in_valid && advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_q      <= '{addr: '0, kind: KIND_DEMAND};
            remain_q   <= '0;
            dem_page_q <= '0;
        end else if (take_miss) begin
            out_valid  <= 1'b1;
            out_q      <= '{addr: in_demand_addr, kind: KIND_DEMAND};
            remain_q   <= in_budget;
            dem_page_q <= in_demand_addr[ADDR_W-1:PG_W];
        end else if (advance) begin
            if (remain_q != '0) begin
                out_valid <= 1'b1;
                out_q     <= '{addr: step_addr, kind: KIND_PREFETCH};
                remain_q  <= remain_q - cnt_t'(1);
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_q));

    // R4
    page_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_q.kind == KIND_PREFETCH |-> out_q.addr[ADDR_W-1:PG_W] == dem_page_q);

    // R4
    step_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && remain_q != '0 |-> step_same_page);

    // R3
    pf_step_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid && remain_q != '0 |=>
        out_valid && out_q.kind == KIND_PREFETCH &&
        out_q.addr == $past(out_q.addr) + paddr_t'(BLK_BYTES));

    // R2
    demand_first_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && out_q.kind == KIND_DEMAND &&
        out_q.addr[OFF_W-1:0] == '0);

    // R5
    last_blk_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && (&in_addr[PG_W-1:OFF_W]) |=> remain_q == '0);

    // R9
    run_end_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid && remain_q == '0 |=> !out_valid);

    // R4
    budget_cap_chk: assert property (@(posedge clk) disable iff (rst)
        remain_q <= cnt_t'(RUN_LEN));
endmodule

// File: rtl/pfs_seq_prefetcher.sv
module pfs_seq_prefetcher
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_is_pf
);
    paddr_t     dem_addr;
    cnt_t       budget;
    paddr_t     nxt_addr;
    logic       same_page;
    fetch_req_t cur_req;

    pfs_budget u_budget (
        .miss_addr   (miss_addr),
        .demand_addr (dem_addr),
        .budget      (budget)
    );

    pfs_next_blk u_next (
        .cur_addr  (cur_req.addr),
        .nxt_addr  (nxt_addr),
        .same_page (same_page)
    );

    pfs_run_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .in_valid       (miss_valid),
        .in_ready       (miss_ready),
        .in_addr        (miss_addr),
        .in_demand_addr (dem_addr),
        .in_budget      (budget),
        .step_addr      (nxt_addr),
        .step_same_page (same_page),
        .out_q          (cur_req),
        .out_valid      (fetch_valid),
        .out_ready      (fetch_ready)
    );

    assign fetch_addr  = cur_req.addr;
    assign fetch_is_pf = (cur_req.kind == KIND_PREFETCH);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> !fetch_valid);
endmodule

// File: tb/tb_pfs_seq_prefetcher.sv
module tb_pfs_seq_prefetcher;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst;
    logic          miss_valid;
    logic          miss_ready;
    logic [AW-1:0] miss_addr;
    logic          fetch_valid;
    logic          fetch_ready;
    logic [AW-1:0] fetch_addr;
    logic          fetch_is_pf;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit ready_toggle = 0;

    logic [AW:0] exp_q[$];

    logic          held_v = 0;
    logic [AW-1:0] held_addr;
    logic          held_pf;

    pfs_seq_prefetcher dut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_addr(fetch_addr), .fetch_is_pf(fetch_is_pf)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, msg, act, exp);
        end
    endtask

    // Expected items of one miss: demand block, then min(4, 127-idx) prefetches (R2 R3 R4 R5)
    task automatic push_expected(input logic [AW-1:0] a);
        logic [AW-1:0] base;
        int idx, n;
        base = {a[AW-1:6], 6'b0};
        idx  = int'(a[12:6]);
        n    = 127 - idx;
        if (n > 4) n = 4;
        exp_q.push_back({1'b0, base});
        for (int i = 1; i <= n; i++)
            exp_q.push_back({1'b1, base + AW'(64 * i)});
    endtask

    // Monitor and scoreboard: inspects handshakes that complete at the coming edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            // R8
            check(miss_ready == (!fetch_valid || fetch_ready), "R8", "miss_ready",
                  64'(miss_ready), 64'(!fetch_valid || fetch_ready));
            if (held_v) begin
                // R7
                check(fetch_valid && fetch_addr == held_addr && fetch_is_pf == held_pf,
                      "R7", "held request changed", 64'(fetch_addr), 64'(held_addr));
            end
            held_v    = fetch_valid && !fetch_ready;
            held_addr = fetch_addr;
            held_pf   = fetch_is_pf;
            if (fetch_valid && fetch_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected request", 64'({fetch_is_pf, fetch_addr}), 64'(0));
                end else begin
                    logic [AW:0] e;
                    e = exp_q.pop_front();
                    // R2 R3 R4 R6
                    check({fetch_is_pf, fetch_addr} == e, e[AW] ? "R3" : "R2",
                          "request mismatch", 64'({fetch_is_pf, fetch_addr}), 64'(e));
                end
            end
            if (miss_valid && miss_ready) begin
                // R6: remaining items of the old run are cancelled
                exp_q.delete();
                push_expected(miss_addr);
            end
        end
    end

    initial begin
        fetch_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            if (ready_toggle) fetch_ready = ~fetch_ready;
            else              fetch_ready = 1'b1;
        end
    end

    task automatic send_miss(input logic [AW-1:0] a);
        @(posedge clk);
        #1;
        miss_valid = 1'b1;
        miss_addr  = a;
        do @(negedge clk); while (!miss_ready);
        @(posedge clk);
        #1;
        miss_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 40; i++) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, req, "run length", 64'(exp_q.size()), 64'(0));
        // R9
        check(!fetch_valid, "R9", "valid after run", 64'(fetch_valid), 64'(0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst        = 1'b1;
        miss_valid = 1'b0;
        miss_addr  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        check(!fetch_valid, "R1", "valid in reset", 64'(fetch_valid), 64'(0));
        #1 rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!fetch_valid && miss_ready, "R1", "after reset",
              64'({fetch_valid, miss_ready}), 64'(2'b01));

        for (int pass = 0; pass < 2; pass++) begin
            ready_toggle = (pass == 1);
            send_miss(40'h12_3456_0040);      // mid page: full run (R3)
            drain("R3");
            send_miss(40'h00_0000_3FC0);      // last block of page (R5)
            drain("R5");
            send_miss(40'h0A_BCDE_1F40);      // two blocks left (R4)
            drain("R4");
            send_miss(40'h77_0000_0123);      // unaligned (R2)
            drain("R2");
        end

        ready_toggle = 0;
        // R6: second miss cuts a run short
        send_miss(40'h55_0000_0400);
        @(posedge clk);
        send_miss(40'h66_0000_0800);
        drain("R6");

        ready_toggle = 1;
        send_miss(40'h55_0000_1000);
        @(posedge clk);
        send_miss(40'h44_0000_1FC0);
        drain("R6");

        finish_run();
    end
endmodule